// File: doc/BRIEF.md
# Sound CPU I/O Decoder with ROM Overlay

This block sits between a small sound CPU and the 64 KB memory behind it. It looks at every CPU byte access. Accesses outside the register page 0x00F0–0x00FF go to RAM. One exception is the top 64 bytes of memory, where a boot ROM can shadow RAM on reads. Accesses inside the register page become strobes and data toward three external timers, an indirect port into a 128-register audio processor, and clear pulses for four communication port bytes.

The RAM, the timers and the audio processor are outside this block. The block drives the RAM write enable, and multiplexes the read data from RAM, the audio processor, the counter values or the ROM image. The ROM image is a 512-bit parameter. Byte n of the image sits at bits [8n+7:8n] and answers address 0xFFC0+n.

The CPU presents an address with a one-cycle read or write pulse, never both at once. Read data and every strobe are combinational on the access cycle. Register state (index copy, timer enables, ROM switch) updates at the clock edge that ends the access.

Top module: `snd_io_decode`

## Requirements
- R1: A write below 0x00F0 asserts ram_we with the CPU address and data and raises no other strobe. A read there returns ram_rdata.
- R2: A write to 0x00F2 is stored in RAM and also captured as the audio index. A read of 0x00F3 asserts dsp_rd with dsp_addr equal to the low 7 bits of the index, and returns dsp_rdata.
- R3: A write to 0x00F3 asserts dsp_wr with dsp_addr = index and dsp_wdata = CPU data only when index bit 7 is 0. Otherwise nothing is written. 0x00F3 is never written to RAM.
- R4: After a write to 0x00F1, timer_en[2:0] equals data bits 2:0 from the next cycle on. timer_en is 0 after reset.
- R5: A write to 0x00F1 pulses port_clr[0] when data bit 4 is set (clears bytes 0xF4/0xF5) and port_clr[1] when data bit 5 is set (clears 0xF6/0xF7), in the same cycle.
- R6: Data bit 7 of a 0x00F1 write switches the ROM overlay, which is on after reset. While the overlay is on, reads of 0xFFC0–0xFFFF return the ROM byte for addr[5:0]. While it is off, those reads return ram_rdata.
- R7: Writes to 0xFFC0–0xFFFF always assert ram_we, whether the overlay is on or off.
- R8: A write to 0x00FA+n (n = 0..2) pulses tgt_we[n] with tgt_data = CPU data and is not stored in RAM. A read of 0x00FA–0x00FC returns 0.
- R9: A read of 0x00FD+n returns {4'b0, cnt_val[4n+3:4n]} and pulses cnt_rd[n] for exactly that cycle. A write there pulses cnt_clr[n] and is not stored in RAM.
- R10: A write to 0x00F0 has no effect on RAM. Reads of 0x00F0 and 0x00F1 return 0. 0x00F8 and 0x00F9 behave as ordinary RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_rd | input | 1 | Read access this cycle |
| cpu_wr | input | 1 | Write access this cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data to the CPU |
| ram_rdata | input | 8 | RAM read data at ram_addr |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| dsp_addr | output | 7 | Audio processor register index |
| dsp_wdata | output | 8 | Audio processor write data |
| dsp_rd | output | 1 | Audio processor read strobe |
| dsp_wr | output | 1 | Audio processor write strobe |
| dsp_rdata | input | 8 | Audio processor read data |
| timer_en | output | 3 | Timer enables |
| tgt_we | output | 3 | Timer target write strobes |
| tgt_data | output | 8 | Timer target value |
| cnt_rd | output | 3 | Counter read strobes (counter clears itself) |
| cnt_clr | output | 3 | Counter clear strobes |
| cnt_val | input | 12 | Three 4-bit counter values |
| port_clr | output | 2 | Port pair clear pulses |

## Verification
The assertions check these on every cycle:
- counter read strobes are one-hot and come only with a read;
- audio writes and port clears come only from their own register address;
- timer enables follow the last control write;
- ROM-window writes always reach RAM;
- timer target registers read as zero;
- with the overlay off, ROM-window reads return RAM data.

Some behaviour depends on earlier writes, and only the bench scenarios show it:
- the audio index held across accesses;
- a write with an out-of-range index that is dropped, proven by reading that register back later;
- the overlay switching back and forth over a byte written while it was on;
- the contents of RAM after writes to registers that must not be stored.

// File: rtl/snd_io_decode.sv
module snd_io_decode #(
  parameter logic [511:0] ROM_IMAGE = {16{32'hC35A_960F}}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  input  logic [7:0]  ram_rdata,
  output logic [15:0] ram_addr,
  output logic [7:0]  ram_wdata,
  output logic        ram_we,
  output logic [6:0]  dsp_addr,
  output logic [7:0]  dsp_wdata,
  output logic        dsp_rd,
  output logic        dsp_wr,
  input  logic [7:0]  dsp_rdata,
  output logic [2:0]  timer_en,
  output logic [2:0]  tgt_we,
  output logic [7:0]  tgt_data,
  output logic [2:0]  cnt_rd,
  output logic [2:0]  cnt_clr,
  input  logic [11:0] cnt_val,
  output logic [1:0]  port_clr
);

  logic       io_page, rom_win, ctl_wr, stored;
  logic [3:0] sel;
  logic [7:0] idx_q;
  logic [2:0] ten_q;
  logic       rom_q;

  assign io_page = cpu_addr[15:4] == 12'h00F;
  assign rom_win = cpu_addr[15:6] == 10'h3FF;
  assign sel     = cpu_addr[3:0];
  assign ctl_wr  = cpu_wr && io_page && sel == 4'h1;

  always_comb begin
    case (sel)
      4'h2, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9: stored = 1'b1;
      default:                                  stored = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      ten_q <= 3'b000;
      rom_q <= 1'b1;
    end else begin
      if (cpu_wr && io_page && sel == 4'h2) idx_q <= cpu_wdata;
      if (ctl_wr) begin
        ten_q <= cpu_wdata[2:0];
        rom_q <= cpu_wdata[7];
      end
    end
  end

  assign ram_addr  = cpu_addr;
  assign ram_wdata = cpu_wdata;
  assign ram_we    = cpu_wr && (!io_page || stored);

  assign dsp_addr  = idx_q[6:0];
  assign dsp_wdata = cpu_wdata;
  assign dsp_rd    = cpu_rd && io_page && sel == 4'h3;
  assign dsp_wr    = cpu_wr && io_page && sel == 4'h3 && !idx_q[7];

  assign timer_en  = ten_q;
  assign tgt_data  = cpu_wdata;
  assign port_clr  = ctl_wr ? cpu_wdata[5:4] : 2'b00;

  for (genvar t = 0; t < 3; t++) begin : g_tmr
    assign tgt_we[t]  = cpu_wr && io_page && sel == 4'(4'hA + t);
    assign cnt_rd[t]  = cpu_rd && io_page && sel == 4'(4'hD + t);
    assign cnt_clr[t] = cpu_wr && io_page && sel == 4'(4'hD + t);
  end

  always_comb begin
    cpu_rdata = ram_rdata;
    if (io_page) begin
      case (sel)
        4'h0, 4'h1, 4'hA, 4'hB, 4'hC: cpu_rdata = 8'h00;
        4'h3: cpu_rdata = dsp_rdata;
        4'hD: cpu_rdata = {4'h0, cnt_val[3:0]};
        4'hE: cpu_rdata = {4'h0, cnt_val[7:4]};
        4'hF: cpu_rdata = {4'h0, cnt_val[11:8]};
        default: cpu_rdata = ram_rdata;
      endcase
    end else if (rom_win && rom_q) begin
      cpu_rdata = ROM_IMAGE[{cpu_addr[5:0], 3'b000} +: 8];
    end
  end

endmodule

// File: rtl/snd_io_decode_chk.sv
module snd_io_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [7:0]  cpu_wdata,
  input logic [7:0]  cpu_rdata,
  input logic [7:0]  ram_rdata,
  input logic        ram_we,
  input logic        dsp_wr,
  input logic [2:0]  timer_en,
  input logic [2:0]  cnt_rd,
  input logic [1:0]  port_clr,
  input logic        rom_q
);

  assert_cnt_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|cnt_rd) |-> (cpu_rd && $onehot0(cnt_rd)));

  assert_timer_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h00F1) |=> (timer_en == $past(cpu_wdata[2:0])));

  assert_dsp_wr_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_wr |-> (cpu_wr && cpu_addr == 16'h00F3 && !ram_we));

  assert_port_clr_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|port_clr) |-> (cpu_wr && cpu_addr == 16'h00F1));

  assert_rom_off_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr[15:6] == 10'h3FF && !rom_q) |-> (cpu_rdata == ram_rdata));

  assert_rom_write_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:6] == 10'h3FF) |-> ram_we);

  assert_tgt_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr >= 16'h00FA && cpu_addr <= 16'h00FC) |-> (cpu_rdata == 8'h00));

endmodule

bind snd_io_decode snd_io_decode_chk u_chk (.*);

// File: tb/snd_io_decode_test.sv
`timescale 1ns/100ps
module snd_io_decode_test;

  function automatic logic [511:0] make_rom();
    logic [511:0] r;
    for (int i = 0; i < 64; i++) r[i*8 +: 8] = 8'((i * 37 + 11) & 255);
    return r;
  endfunction
  localparam logic [511:0] ROM = make_rom();

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [15:0] cpu_addr = 0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [7:0] cpu_wdata = 0, ram_rdata, dsp_rdata, cpu_rdata, ram_wdata, dsp_wdata, tgt_data;
  logic [15:0] ram_addr;
  logic ram_we, dsp_rd, dsp_wr;
  logic [6:0] dsp_addr;
  logic [2:0] timer_en, tgt_we, cnt_rd, cnt_clr;
  logic [11:0] cnt_val = 12'h000;
  logic [1:0] port_clr;

  snd_io_decode #(.ROM_IMAGE(ROM)) uut (.*);

  logic [7:0] bram [65536];
  logic [7:0] dregs [128];
  always @(posedge clk) begin
    if (ram_we) bram[ram_addr] <= ram_wdata;
    if (dsp_wr) dregs[dsp_addr] <= dsp_wdata;
  end
  assign ram_rdata = bram[ram_addr];
  assign dsp_rdata = dregs[dsp_addr];

  logic [7:0] mref [65536];
  logic [7:0] dref [128];
  int m_idx = 0, m_ten = 0, m_rom = 1;
  int vectors = 0, errs = 0, cycles = 0;
  bit done = 0;

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit rd, input bit wr, input logic [15:0] a, input logic [7:0] d,
                      input string tag);
    bit io, we_e, dwr_e;
    int s, rexp;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    #1;
    vectors++;
    io = a[15:4] == 12'h00F;
    s = int'(a[3:0]);
    we_e = wr && (!io || s == 2 || (s >= 4 && s <= 9));
    dwr_e = wr && io && s == 3 && m_idx < 128;
    cmp(tag, "ram_we", int'(ram_we), int'(we_e));
    if (we_e) begin
      cmp(tag, "ram_addr", int'(ram_addr), int'(a));
      cmp(tag, "ram_wdata", int'(ram_wdata), int'(d));
    end
    cmp(tag, "dsp_rd", int'(dsp_rd), int'(rd && io && s == 3));
    cmp(tag, "dsp_wr", int'(dsp_wr), int'(dwr_e));
    if (dsp_rd || dsp_wr) cmp(tag, "dsp_addr", int'(dsp_addr), m_idx % 128);
    if (dwr_e) cmp(tag, "dsp_wdata", int'(dsp_wdata), int'(d));
    for (int t = 0; t < 3; t++) begin
      cmp(tag, "tgt_we", int'(tgt_we[t]), int'(wr && io && s == 10 + t));
      cmp(tag, "cnt_rd", int'(cnt_rd[t]), int'(rd && io && s == 13 + t));
      cmp(tag, "cnt_clr", int'(cnt_clr[t]), int'(wr && io && s == 13 + t));
    end
    if (|tgt_we) cmp(tag, "tgt_data", int'(tgt_data), int'(d));
    cmp(tag, "port_clr", int'(port_clr), (wr && io && s == 1) ? int'(d[5:4]) : 0);
    cmp(tag, "timer_en", int'(timer_en), m_ten);
    if (rd) begin
      if (io && (s == 0 || s == 1 || (s >= 10 && s <= 12))) rexp = 0;
      else if (io && s == 3) rexp = dref[m_idx % 128];
      else if (io && s >= 13) rexp = (cnt_val >> (4 * (s - 13))) & 15;
      else if (a >= 16'hFFC0 && m_rom == 1) rexp = int'(ROM[a[5:0]*8 +: 8]);
      else rexp = mref[a];
      cmp(tag, "cpu_rdata", int'(cpu_rdata), rexp);
    end
    @(posedge clk);
    if (we_e) mref[a] = d;
    if (dwr_e) dref[m_idx % 128] = d;
    if (wr && io && s == 2) m_idx = d;
    if (wr && io && s == 1) begin m_ten = d & 7; m_rom = d[7]; end
    #0.5;
    cpu_rd = 0; cpu_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errs++;
      $display("FAIL watchdog: actual %0d expected below 50000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 65536; i++) begin bram[i] = 8'((i * 7 + 3) & 255); mref[i] = bram[i]; end
    for (int i = 0; i < 128; i++) begin dregs[i] = 8'(i ^ 8'h5A); dref[i] = dregs[i]; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // reset state: timers off, overlay on
    step(0, 0, 16'h0000, 8'h00, "R4");
    step(1, 0, 16'hFFC0, 8'h00, "R6");
    step(1, 0, 16'hFFFF, 8'h00, "R6");
    // plain RAM
    step(0, 1, 16'h0010, 8'hA7, "R1");
    step(1, 0, 16'h0010, 8'h00, "R1");
    step(0, 1, 16'h00EF, 8'h3C, "R1");
    step(1, 0, 16'h00EF, 8'h00, "R1");
    // indirect port
    step(0, 1, 16'h00F2, 8'h05, "R2");
    step(1, 0, 16'h00F2, 8'h00, "R2");
    step(1, 0, 16'h00F3, 8'h00, "R2");
    step(0, 1, 16'h00F3, 8'hC1, "R3");
    step(1, 0, 16'h00F3, 8'h00, "R3");
    step(0, 1, 16'h00F2, 8'h85, "R3");
    step(0, 1, 16'h00F3, 8'hAA, "R3");
    step(1, 0, 16'h00F3, 8'h00, "R2");
    step(0, 1, 16'h00F2, 8'h05, "R3");
    step(1, 0, 16'h00F3, 8'h00, "R3");
    // control register
    step(0, 1, 16'h00F1, 8'h07, "R4");
    step(1, 0, 16'h00F1, 8'h00, "R10");
    step(0, 1, 16'h00F1, 8'h35, "R5");
    step(0, 1, 16'h00F1, 8'h12, "R5");
    step(0, 1, 16'h00F1, 8'h20, "R5");
    step(1, 0, 16'hFFC0, 8'h00, "R6");
    step(0, 1, 16'hFFC5, 8'h99, "R7");
    step(1, 0, 16'hFFC5, 8'h00, "R7");
    step(0, 1, 16'h00F1, 8'h80, "R6");
    step(0, 1, 16'hFFC6, 8'h42, "R7");
    step(1, 0, 16'hFFC6, 8'h00, "R6");
    step(0, 1, 16'h00F1, 8'h00, "R6");
    step(1, 0, 16'hFFC6, 8'h00, "R7");
    step(1, 0, 16'hFFBF, 8'h00, "R6");
    // timer targets and counters
    step(0, 1, 16'h00FA, 8'h10, "R8");
    step(0, 1, 16'h00FB, 8'h00, "R8");
    step(0, 1, 16'h00FC, 8'hFF, "R8");
    step(1, 0, 16'h00FA, 8'h00, "R8");
    step(1, 0, 16'h00FC, 8'h00, "R8");
    cnt_val = 12'hA5C;
    step(1, 0, 16'h00FD, 8'h00, "R9");
    step(1, 0, 16'h00FE, 8'h00, "R9");
    step(1, 0, 16'h00FF, 8'h00, "R9");
    step(0, 1, 16'h00FE, 8'h77, "R9");
    // test register and plain registers
    step(0, 1, 16'h00F0, 8'h55, "R10");
    step(1, 0, 16'h00F0, 8'h00, "R10");
    step(0, 1, 16'h00F8, 8'h61, "R10");
    step(0, 1, 16'h00F9, 8'h62, "R10");
    step(1, 0, 16'h00F8, 8'h00, "R10");
    step(1, 0, 16'h00F9, 8'h00, "R10");
    // mixed traffic
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cnt_val = {lf[11:0]};
      case (lf[1:0])
        2'd0: a = {8'h00, 4'hF, lf[7:4]};
        2'd1: a = {10'h3FF, lf[9:4]};
        2'd2: a = {8'h00, lf[11:4]};
        default: a = lf;
      endcase
      step(lf[14], !lf[14], a, lf[15:8] ^ lf[7:0], "R1");
    end
    finish_run();
  end

endmodule